// File: doc/BRIEF.md
# Debug Reset and Halt Controller

This block sits between a timer module's debug port, the device reset tree and the JTAG test access port. It owns the reset domain of the debug logic, holds a small control register written from the test-clock side, and decides when the timer module must be halted. Only power-on reset and a dedicated debug-port reset clear it. System reset leaves it alone, so debug settings made before a system reset are still in force afterwards.

The halt request combines three things: a system debug level driven by other on-chip logic, a software halt bit in the control register, and a boot-halt latch. The latch records a debug request that is present on the last cycle of a system reset, so the timer module comes out of reset already halted. Two enable bits decide whether either external or boot-time halting is allowed. The block also gates the TAP inputs and the auxiliary output pins while its own reset is active.

Top module: `dbg_halt_ctl`

## Requirements
- R1: Asserting `por_i` or `dbg_rst_i` clears `halt_o`, `aux_data_o`, `aux_oe_o` and `cfg_rdata_o` at once, without waiting for a clock edge. Each clock domain leaves reset two of its own clock edges after both reset inputs are low.
- R2: A system reset (`sys_rst_i`) changes neither the control register (`cfg_rdata_o`) nor the auxiliary output path.
- R3: While the block reset is active, `aux_data_o` and `aux_oe_o` are 0. Outside reset they repeat `aux_data_i` and `aux_en_i` one `clk` cycle later.
- R4: While `dbg_rst_i` is high, `tms_o` is 1, `tck_en_o` is 0 and `tap_reset_o` is 1. While either `por_i` or `dbg_rst_i` is high, `tdi_o` is 0. In all other cases, `tms_o` follows `tms_i`, `tdi_o` follows `tdi_i`, `tck_en_o` is 1 and `tap_reset_o` is 0.
- R5: A `tck` edge with `tap_tlr_i` high clears the control register, even if a write is presented in the same cycle.
- R6: The control register has three bits: bit 0 is the global debug enable, bit 1 is the system-debug enable and bit 2 is the software halt request. It loads `cfg_wdata_i` on a `tck` edge with `cfg_we_i` high, and `cfg_rdata_o` shows its contents.
- R7: Outside system reset, with the boot-halt latch clear, `halt_o` equals `gde & ((sde & sys_dbg_i) | swh)` one `clk` cycle after the inputs. The control bits arrive through a two-flop synchronizer.
- R8: `halt_o` is 0 on every cycle that follows a `clk` edge at which `sys_rst_i` was high.
- R9: If `sys_dbg_i` is high on the last cycle of system reset and both enables are set, `halt_o` is 1 on the first cycle after reset. If `sys_dbg_i` is low on that last cycle, no boot halt occurs, whatever level it had earlier in the reset.
- R10: A boot halt stays in force while `sys_dbg_i` is low and no software request is present. It ends only once the global enable and the software halt bit are seen set together; after that `halt_o` follows R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer-module side clock |
| tck | input | 1 | Test clock |
| por_i | input | 1 | Power-on reset, async, active high |
| dbg_rst_i | input | 1 | Dedicated debug-port reset, async, active high |
| sys_rst_i | input | 1 | System reset level, synchronous to clk |
| sys_dbg_i | input | 1 | System debug request level, synchronous to clk |
| tap_tlr_i | input | 1 | TAP controller is in Test-Logic-Reset (tck domain) |
| cfg_we_i | input | 1 | Control register write strobe (tck domain) |
| cfg_wdata_i | input | 3 | Control register write data |
| cfg_rdata_o | output | 3 | Control register contents |
| tms_i | input | 1 | TMS from pin |
| tdi_i | input | 1 | TDI from pin |
| tms_o | output | 1 | Gated TMS to TAP controller |
| tdi_o | output | 1 | Gated TDI to TAP controller |
| tck_en_o | output | 1 | Test clock enable for TAP controller |
| tap_reset_o | output | 1 | Forces TAP controller into Test-Logic-Reset |
| aux_data_i | input | AUX_W | Auxiliary output data from message logic |
| aux_en_i | input | 1 | Auxiliary output enable from message logic |
| aux_data_o | output | AUX_W | Registered auxiliary output data pins |
| aux_oe_o | output | 1 | Registered auxiliary output enable |
| halt_o | output | 1 | Halt request to timer module |

## Verification
The halt function is swept over all sixteen combinations of the two enables, the software bit and the system debug level. This separates the gating by the global enable from the gating by the system-debug enable, and both from the software path. Reset-exit cases vary the enables and the debug level on the final reset cycle, and one case has the request present early in reset but gone on the last cycle, which shows that only the final cycle is sampled. All 256 auxiliary data values are pushed through, and resets are applied in the middle of a run. This tells an asynchronous clear from a synchronous one, and shows that system reset leaves the control register and the auxiliary path untouched while the debug-port reset and the TAP reset state both clear them.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int CTRL_W = 3;

  typedef struct packed {
    logic swh;   // bit 2: software halt request
    logic sde;   // bit 1: system-debug enable
    logic gde;   // bit 0: global debug enable
  } ctrl_t;
endpackage

// File: rtl/dbg_rst_sync.sv
// Reset that asserts asynchronously and releases after STAGES clock edges.
module dbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) pipe <= '1;
    else      pipe <= {pipe[STAGES-2:0], 1'b0};
  end

  assign rst = pipe[STAGES-1];
endmodule

// File: rtl/dbg_bit_sync.sv
// Multi-flop synchronizer for quasi-static control bits.
module dbg_bit_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dbg_ctrl_reg.sv
// Control register in the test-clock domain.
module dbg_ctrl_reg
  import dbg_halt_pkg::*;
(
  input  logic              tck,
  input  logic              rst,
  input  logic              tap_tlr,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl
);
  always_ff @(posedge tck or posedge rst) begin
    if (rst)          ctrl <= '0;
    else if (tap_tlr) ctrl <= '0;
    else if (we)      ctrl <= ctrl_t'(wdata);
  end
endmodule

// File: rtl/dbg_halt_arb.sv
// Halt arbitration with reset-exit capture of the system debug level.
module dbg_halt_arb
  import dbg_halt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sys_rst,
  input  logic  sys_dbg,
  input  ctrl_t ctrl,
  output logic  boot_lat,
  output logic  halt
);
  logic sys_rst_d;
  logic cap;
  logic boot_set;
  logic sw_take;
  logic halt_next;

  assign boot_set  = sys_rst_d & ~sys_rst & cap & ctrl.gde & ctrl.sde;
  assign sw_take   = ctrl.gde & ctrl.swh;
  assign halt_next = ~sys_rst &
                     (boot_set | boot_lat |
                      (ctrl.gde & ((ctrl.sde & sys_dbg) | ctrl.swh)));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sys_rst_d <= 1'b0;
      cap       <= 1'b0;
      boot_lat  <= 1'b0;
      halt      <= 1'b0;
    end else begin
      sys_rst_d <= sys_rst;
      if (sys_rst) cap <= sys_dbg;
      if (sys_rst)       boot_lat <= 1'b0;
      else if (boot_set) boot_lat <= 1'b1;
      else if (sw_take)  boot_lat <= 1'b0;
      halt <= halt_next;
    end
  end
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_halt_pkg::*;
#(
  parameter int AUX_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              tck,
  input  logic              por_i,
  input  logic              dbg_rst_i,
  input  logic              sys_rst_i,
  input  logic              sys_dbg_i,
  input  logic              tap_tlr_i,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              tck_en_o,
  output logic              tap_reset_o,
  input  logic [AUX_W-1:0]  aux_data_i,
  input  logic              aux_en_i,
  output logic [AUX_W-1:0]  aux_data_o,
  output logic              aux_oe_o,
  output logic              halt_o
);
  logic  blk_rst_raw;
  logic  rst_c;
  logic  rst_t;
  ctrl_t ctrl_t_q;
  ctrl_t ctrl_s;
  logic  boot_lat;
  logic  gde_s;
  logic  sde_s;

  assign blk_rst_raw = por_i | dbg_rst_i;

  dbg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_clk (
    .clk(clk), .arst(blk_rst_raw), .rst(rst_c));

  dbg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_tck (
    .clk(tck), .arst(blk_rst_raw), .rst(rst_t));

  dbg_ctrl_reg u_ctrl (
    .tck(tck), .rst(rst_t), .tap_tlr(tap_tlr_i),
    .we(cfg_we_i), .wdata(cfg_wdata_i), .ctrl(ctrl_t_q));

  assign cfg_rdata_o = ctrl_t_q;

  dbg_bit_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk(clk), .rst(rst_c), .d(ctrl_t_q), .q(ctrl_s));

  assign gde_s = ctrl_s.gde;
  assign sde_s = ctrl_s.sde;

  dbg_halt_arb u_arb (
    .clk(clk), .rst(rst_c), .sys_rst(sys_rst_i), .sys_dbg(sys_dbg_i),
    .ctrl(ctrl_s), .boot_lat(boot_lat), .halt(halt_o));

  // Auxiliary output pins: registered, negated while in reset.
  always_ff @(posedge clk or posedge rst_c) begin
    if (rst_c) begin
      aux_data_o <= '0;
      aux_oe_o   <= 1'b0;
    end else begin
      aux_data_o <= aux_data_i;
      aux_oe_o   <= aux_en_i;
    end
  end

  // TAP input gating.
  assign tms_o       = tms_i | dbg_rst_i;
  assign tck_en_o    = ~dbg_rst_i;
  assign tap_reset_o = dbg_rst_i;
  assign tdi_o       = tdi_i & ~blk_rst_raw;
endmodule

// File: rtl/dbg_halt_ctl_chk.sv
module dbg_halt_ctl_chk #(
  parameter int AUX_W = 8
) (
  input logic             clk,
  input logic             rst_c,
  input logic             dbg_rst_i,
  input logic             sys_rst_i,
  input logic             sys_dbg_i,
  input logic             gde_s,
  input logic             sde_s,
  input logic             halt_o,
  input logic [AUX_W-1:0] aux_data_o,
  input logic             aux_oe_o,
  input logic             tms_o,
  input logic             tck_en_o,
  input logic             tap_reset_o
);
  // R3: auxiliary pins negated during block reset
  always @(negedge clk) begin
    if (rst_c) begin
      a_r3_aux_quiet: assert (aux_oe_o == 1'b0 && aux_data_o == '0);
    end
  end

  // R4: TAP forced while the debug-port reset is high
  always @(negedge clk) begin
    if (dbg_rst_i) begin
      a_r4_tap_forced: assert (tms_o && !tck_en_o && tap_reset_o);
    end
  end

  // R8: no halt after a cycle in system reset
  a_r8_no_halt_in_reset: assert property (@(posedge clk) disable iff (rst_c)
    sys_rst_i |=> !halt_o);

  // R7: enabled system debug level halts
  a_r7_sys_dbg_halts: assert property (@(posedge clk) disable iff (rst_c)
    (!sys_rst_i && sys_dbg_i && gde_s && sde_s) |=> halt_o);

  // R9: request on final reset cycle gives halt right after reset
  a_r9_boot_halt: assert property (@(posedge clk) disable iff (rst_c)
    (sys_rst_i && sys_dbg_i) ##1 (!sys_rst_i && gde_s && sde_s) |=> halt_o);
endmodule

bind dbg_halt_ctl dbg_halt_ctl_chk #(.AUX_W(AUX_W)) u_chk (
  .clk(clk), .rst_c(rst_c), .dbg_rst_i(dbg_rst_i), .sys_rst_i(sys_rst_i),
  .sys_dbg_i(sys_dbg_i), .gde_s(gde_s), .sde_s(sde_s), .halt_o(halt_o),
  .aux_data_o(aux_data_o), .aux_oe_o(aux_oe_o), .tms_o(tms_o),
  .tck_en_o(tck_en_o), .tap_reset_o(tap_reset_o));

// File: tb/dbg_halt_ctl_test.sv
module dbg_halt_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_PERIOD = 16;
  localparam int AUX_W      = 8;

  logic clk = 0, tck = 0;
  logic por_i = 1, dbg_rst_i = 0, sys_rst_i = 0, sys_dbg_i = 0, tap_tlr_i = 0;
  logic cfg_we_i = 0;
  logic [2:0] cfg_wdata_i = 0, cfg_rdata_o;
  logic tms_i = 0, tdi_i = 0, tms_o, tdi_o, tck_en_o, tap_reset_o;
  logic [AUX_W-1:0] aux_data_i = 0, aux_data_o;
  logic aux_en_i = 0, aux_oe_o, halt_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(TCK_PERIOD/2) tck = ~tck;

  dbg_halt_ctl #(.AUX_W(AUX_W)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [2:0] v);
    @(negedge tck); cfg_we_i = 1; cfg_wdata_i = v;
    @(negedge tck); cfg_we_i = 0;
    clks(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    aux_data_i = 8'hA5; aux_en_i = 1; tdi_i = 1; tms_i = 0;
    clks(3);
    // R1 / R3: reset state under power-on reset
    check("R1 halt in por", halt_o, 0);
    check("R1 cfg in por", cfg_rdata_o, 0);
    check("R3 aux data in por", aux_data_o, 0);
    check("R3 aux oe in por", aux_oe_o, 0);
    // R4: por gates TDI but not TMS
    check("R4 tdi gated by por", tdi_o, 0);
    check("R4 tms not forced by por", tms_o, 0);
    check("R4 tck enabled under por", tck_en_o, 1);
    por_i = 0;
    clks(5);
    check("R4 tdi passes", tdi_o, 1);

    // R3: exhaustive aux data sweep, one-cycle latency
    for (int v = 0; v < 256; v++) begin
      aux_data_i = v[7:0]; aux_en_i = v[0];
      @(negedge clk);
      check("R3 aux data", aux_data_o, v);
      check("R3 aux oe", aux_oe_o, v[0]);
    end

    // R6: register write and readback
    wr_cfg(3'b101);
    check("R6 cfg readback", cfg_rdata_o, 3'b101);
    // R5: TAP reset state clears, even against a write
    @(negedge tck); tap_tlr_i = 1; cfg_we_i = 1; cfg_wdata_i = 3'b111;
    @(negedge tck); tap_tlr_i = 0; cfg_we_i = 0;
    check("R5 tlr clears cfg", cfg_rdata_o, 0);

    // R7: all combinations of gde, sde, swh, sys_dbg
    for (int i = 0; i < 16; i++) begin
      sys_dbg_i = i[3];
      wr_cfg(i[2:0]);
      check("R7 halt sweep", halt_o, i[0] & ((i[1] & i[3]) | i[2]));
    end
    sys_dbg_i = 0;

    // R2: system reset keeps cfg and aux path
    wr_cfg(3'b011);
    aux_data_i = 8'h3C; aux_en_i = 1;
    @(negedge clk); sys_rst_i = 1;
    clks(4);
    check("R2 cfg kept in sys reset", cfg_rdata_o, 3'b011);
    check("R2 aux path in sys reset", aux_data_o, 8'h3C);
    sys_rst_i = 0;
    clks(2);
    check("R2 cfg kept after sys reset", cfg_rdata_o, 3'b011);

    // R9 / R8 / R10: boot halt for each enable pair and final level
    for (int k = 0; k < 8; k++) begin
      // k[0]=gde k[1]=sde k[2]=level on final reset cycle
      wr_cfg({1'b0, k[1], k[0]});
      @(negedge clk); sys_rst_i = 1; sys_dbg_i = 1;
      clks(3);
      check("R8 no halt during sys reset", halt_o, 0);
      sys_dbg_i = k[2];
      @(negedge clk); sys_rst_i = 0; sys_dbg_i = 0;
      @(negedge clk);
      check("R9 boot halt first cycle", halt_o, k[0] & k[1] & k[2]);
      clks(4);
      check("R10 boot halt held", halt_o, k[0] & k[1] & k[2]);
      if (k[0] & k[1] & k[2]) begin
        wr_cfg(3'b111);
        check("R10 halt under sw request", halt_o, 1);
        wr_cfg(3'b011);
        check("R10 boot halt released", halt_o, 0);
      end
    end

    // R1 / R4: debug-port reset mid-run clears asynchronously
    aux_data_i = 8'hFF; aux_en_i = 1; tms_i = 0;
    wr_cfg(3'b111);
    clks(1);
    #2 dbg_rst_i = 1;
    #1;
    check("R1 aux async clear", aux_data_o, 0);
    check("R1 halt async clear", halt_o, 0);
    check("R1 cfg async clear", cfg_rdata_o, 0);
    check("R4 tms forced", tms_o, 1);
    check("R4 tck disabled", tck_en_o, 0);
    check("R4 tap reset", tap_reset_o, 1);
    check("R4 tdi gated", tdi_o, 0);
    clks(3);
    check("R3 aux oe held in dbg reset", aux_oe_o, 0);
    dbg_rst_i = 0;
    clks(5);
    check("R4 tap released", {tms_o, tck_en_o, tap_reset_o}, 3'b010);
    check("R3 aux resumes", aux_data_o, 8'hFF);

    finish_run();
  end
endmodule